// File: doc/BRIEF.md
# Paged Address Translator with Tagged Lookaside Buffer

This block turns a logical address from a processor into a physical address. The upper bits of the logical address select a page and the lower bits give the byte within that page. A small, fully associative lookaside buffer holds recent page-to-frame mappings. Each buffer entry is tagged with the address-space identifier of the process that loaded it. When the buffer does not hold the mapping, the block reads a page table kept in a register array. That table is loaded through a simple write port.

A request enters through a valid/ready handshake. Each request gives a logical address, an access kind and the current address-space identifier. Exactly one response pulse comes back. It carries either the physical address or a fault cause. The block checks every request against a page-count bound. On a table walk it also checks the entry's valid bit and its protection field. Only a mapping that passes all checks is placed in the buffer. A flush input drops every buffered mapping, for example when the table is rewritten.

Top module: `paged_xlate`

## Requirements
- R1: After synchronous reset `req_ready` is 1 and `resp_valid` is 0. The buffer is empty, so the first in-range access to any page takes the table-walk path.
- R2: The page number is `req_vaddr[VPN_W+OFF_W-1:OFF_W]` and the offset is `req_vaddr[OFF_W-1:0]`. A good response returns `resp_paddr = frame * 2**OFF_W + offset` with `resp_fault = 0`. Example with 4-byte pages: page 0 in frame 5 gives address 0 → 20 and 3 → 23. Page 1 in frame 6 gives 4 → 24. Page 3 in frame 2 gives 13 → 9.
- R3: A buffer hit raises `resp_valid` for one cycle. It does so at the clock edge right after the edge that accepted the request.
- R4: A miss drops `req_ready` for exactly two cycles. `resp_valid` pulses on the third edge after acceptance. A mapping filled this way makes the next access to the same page and identifier a hit.
- R5: A hit needs both the page number and the address-space identifier to match a valid entry. The same page under another identifier misses and fills its own entry.
- R6: A page number at or above `pt_len` answers with fault 1 (length) after one cycle. This happens even when the page is buffered, and no table walk takes place.
- R7: A walk that finds the table entry's valid bit clear answers with fault 2 (invalid page). Nothing is filled, so a repeat access walks again.
- R8: The protection field is 0 for read only, 1 for read and write, 2 for execute only, and 3 for no access. The access kind is 0 for read, 1 for write, 2 for execute. A kind the field does not allow answers with fault 3, on both the hit path and the walk path. A walk that ends in fault 3 fills nothing.
- R9: A fill takes the lowest-numbered empty buffer slot if one exists. Otherwise it evicts the slot named by a round-robin pointer, which starts at 0 and advances by one per eviction.
- R10: After `flush` is asserted for a cycle, every access misses until it is refilled.
- R11: Every faulting response drives `resp_paddr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vaddr | input | VPN_W+OFF_W | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| cur_asid | input | ASID_W | Address-space identifier of the requester |
| pt_len | input | VPN_W+1 | Number of legal pages |
| flush | input | 1 | Invalidate all buffer entries |
| pt_we | input | 1 | Page-table write strobe |
| pt_waddr | input | VPN_W | Page-table entry index |
| pt_wvalid | input | 1 | Valid bit to write |
| pt_wprot | input | 2 | Protection field to write |
| pt_wframe | input | FRAME_W | Frame number to write |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_paddr | output | FRAME_W+OFF_W | Physical address (0 on fault) |
| resp_fault | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |

## Verification
The assertions assume three things about the inputs. A request is offered only while `req_ready` is high. The page table and `pt_len` stay unchanged while a walk is in flight. `flush` is not raised in the cycle that completes a walk, which would otherwise leave a freshly filled entry and break the "flush leaves no match" property. The stimulus keeps to these assumptions. It issues requests only after checking `req_ready`, and it changes table contents, bound and flush only between responses, with the block idle. Within those limits it varies the identifier, the access kind and the bound, so that every fault code and both latency paths occur.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    localparam logic [1:0] FLT_NONE    = 2'd0;
    localparam logic [1:0] FLT_LEN     = 2'd1;
    localparam logic [1:0] FLT_INVALID = 2'd2;
    localparam logic [1:0] FLT_PROT    = 2'd3;

    localparam logic [1:0] PROT_RO = 2'd0;
    localparam logic [1:0] PROT_RW = 2'd1;
    localparam logic [1:0] PROT_XO = 2'd2;

    localparam logic [1:0] ACC_RD = 2'd0;
    localparam logic [1:0] ACC_WR = 2'd1;
    localparam logic [1:0] ACC_EX = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2
    } walk_st_e;

    function automatic logic prot_allows(input logic [1:0] prot, input logic [1:0] kind);
        case (prot)
            PROT_RO: return kind == ACC_RD;
            PROT_RW: return (kind == ACC_RD) || (kind == ACC_WR);
            PROT_XO: return kind == ACC_EX;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pxl_table.sv
module pxl_table #(
    parameter int VPN_W   = 4,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [VPN_W-1:0]   waddr,
    input  logic               wvalid,
    input  logic [1:0]         wprot,
    input  logic [FRAME_W-1:0] wframe,
    input  logic [VPN_W-1:0]   raddr,
    output logic               rvalid,
    output logic [1:0]         rprot,
    output logic [FRAME_W-1:0] rframe
);
    localparam int DEPTH = 1 << VPN_W;

    logic [DEPTH-1:0]   ent_v_q;
    logic [1:0]         ent_prot_q  [DEPTH];
    logic [FRAME_W-1:0] ent_frame_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_v_q <= '0;
        end else if (we) begin
            ent_v_q[waddr] <= wvalid;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            ent_prot_q[waddr]  <= wprot;
            ent_frame_q[waddr] <= wframe;
        end
    end

    assign rvalid = ent_v_q[raddr];
    assign rprot  = ent_prot_q[raddr];
    assign rframe = ent_frame_q[raddr];

endmodule

// File: rtl/pxl_tlb.sv
module pxl_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 4,
    parameter int ASID_W  = 4,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic [ENTRIES-1:0] match_vec,
    output logic [FRAME_W-1:0] match_frame,
    output logic [1:0]         match_prot,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [ASID_W-1:0]  fill_asid,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic [1:0]         fill_prot
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] slot_v_q;
    logic [VPN_W-1:0]   slot_vpn_q   [ENTRIES];
    logic [ASID_W-1:0]  slot_asid_q  [ENTRIES];
    logic [FRAME_W-1:0] slot_frame_q [ENTRIES];
    logic [1:0]         slot_prot_q  [ENTRIES];
    logic [IDX_W-1:0]   rr_q;

    logic               have_free;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   victim;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match_vec[g] = slot_v_q[g] && (slot_vpn_q[g] == lk_vpn)
                                  && (slot_asid_q[g] == lk_asid);
        end
    endgenerate

    always_comb begin
        match_frame = '0;
        match_prot  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                match_frame = match_frame | slot_frame_q[i];
                match_prot  = match_prot  | slot_prot_q[i];
            end
        end
    end

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!slot_v_q[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        victim = have_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v_q <= '0;
            rr_q     <= '0;
        end else begin
            if (flush) begin
                slot_v_q <= '0;
            end
            if (fill_en) begin
                slot_v_q[victim] <= 1'b1;
                if (!have_free) begin
                    rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            slot_vpn_q[victim]   <= fill_vpn;
            slot_asid_q[victim]  <= fill_asid;
            slot_frame_q[victim] <= fill_frame;
            slot_prot_q[victim]  <= fill_prot;
        end
    end

endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
    import pxl_pkg::*;
#(
    parameter int VPN_W   = 4,
    parameter int OFF_W   = 2,
    parameter int FRAME_W = 3,
    parameter int ASID_W  = 4,
    parameter int TLB_N   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VPN_W+OFF_W-1:0]   req_vaddr,
    input  logic [1:0]               req_kind,
    input  logic [ASID_W-1:0]        cur_asid,
    input  logic [VPN_W:0]           pt_len,
    input  logic                     flush,
    input  logic                     pt_we,
    input  logic [VPN_W-1:0]         pt_waddr,
    input  logic                     pt_wvalid,
    input  logic [1:0]               pt_wprot,
    input  logic [FRAME_W-1:0]       pt_wframe,
    output logic                     resp_valid,
    output logic [FRAME_W+OFF_W-1:0] resp_paddr,
    output logic [1:0]               resp_fault
);
    localparam int PA_W = FRAME_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic [1:0]       fault;
        logic [PA_W-1:0]  paddr;
    } xl_resp_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [OFF_W-1:0]  off;
        logic [1:0]        kind;
        logic [ASID_W-1:0] asid;
    } xl_req_t;

    walk_st_e          st_q;
    xl_resp_t          resp_q;
    xl_req_t           lat_q;
    logic              pte_v_q;
    logic [1:0]        pte_prot_q;
    logic [FRAME_W-1:0] pte_frame_q;

    logic [VPN_W-1:0]   in_vpn;
    logic [OFF_W-1:0]   in_off;
    logic               accept;
    logic               len_bad;
    logic [TLB_N-1:0]   hit_vec;
    logic               hit;
    logic [FRAME_W-1:0] hit_frame;
    logic [1:0]         hit_prot;
    logic               tbl_v;
    logic [1:0]         tbl_prot;
    logic [FRAME_W-1:0] tbl_frame;
    logic               walk_ok;
    logic               fill_en;

    assign in_vpn    = req_vaddr[VPN_W+OFF_W-1:OFF_W];
    assign in_off    = req_vaddr[OFF_W-1:0];
    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign len_bad   = ({1'b0, in_vpn} >= pt_len);
    assign hit       = |hit_vec;
    assign walk_ok   = pte_v_q && prot_allows(pte_prot_q, lat_q.kind);
    assign fill_en   = (st_q == ST_CHECK) && walk_ok;

    pxl_table #(
        .VPN_W   (VPN_W),
        .FRAME_W (FRAME_W)
    ) table_i (
        .clk    (clk),
        .rst    (rst),
        .we     (pt_we),
        .waddr  (pt_waddr),
        .wvalid (pt_wvalid),
        .wprot  (pt_wprot),
        .wframe (pt_wframe),
        .raddr  (lat_q.vpn),
        .rvalid (tbl_v),
        .rprot  (tbl_prot),
        .rframe (tbl_frame)
    );

    pxl_tlb #(
        .ENTRIES (TLB_N),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .FRAME_W (FRAME_W)
    ) tlb_i (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .lk_vpn      (in_vpn),
        .lk_asid     (cur_asid),
        .match_vec   (hit_vec),
        .match_frame (hit_frame),
        .match_prot  (hit_prot),
        .fill_en     (fill_en),
        .fill_vpn    (lat_q.vpn),
        .fill_asid   (lat_q.asid),
        .fill_frame  (pte_frame_q),
        .fill_prot   (pte_prot_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            resp_q <= '0;
        end else begin
            resp_q.valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (len_bad) begin
                            resp_q <= '{valid: 1'b1, fault: FLT_LEN, paddr: '0};
                        end else if (hit) begin
                            if (prot_allows(hit_prot, req_kind)) begin
                                resp_q <= '{valid: 1'b1, fault: FLT_NONE, paddr: {hit_frame, in_off}};
                            end else begin
                                resp_q <= '{valid: 1'b1, fault: FLT_PROT, paddr: '0};
                            end
                        end else begin
                            st_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    st_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    st_q <= ST_IDLE;
                    if (!pte_v_q) begin
                        resp_q <= '{valid: 1'b1, fault: FLT_INVALID, paddr: '0};
                    end else if (!walk_ok) begin
                        resp_q <= '{valid: 1'b1, fault: FLT_PROT, paddr: '0};
                    end else begin
                        resp_q <= '{valid: 1'b1, fault: FLT_NONE, paddr: {pte_frame_q, lat_q.off}};
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            lat_q <= '{vpn: in_vpn, off: in_off, kind: req_kind, asid: cur_asid};
        end
        if (st_q == ST_FETCH) begin
            pte_v_q     <= tbl_v;
            pte_prot_q  <= tbl_prot;
            pte_frame_q <= tbl_frame;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_paddr = resp_q.paddr;
    assign resp_fault = resp_q.fault;

endmodule

// File: rtl/pxl_chk.sv
module pxl_chk
    import pxl_pkg::*;
#(
    parameter int VPN_W   = 4,
    parameter int OFF_W   = 2,
    parameter int FRAME_W = 3,
    parameter int TLB_N   = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [VPN_W+OFF_W-1:0]   req_vaddr,
    input logic [VPN_W:0]           pt_len,
    input logic                     flush,
    input logic                     resp_valid,
    input logic [1:0]               resp_fault,
    input logic [FRAME_W+OFF_W-1:0] resp_paddr,
    input logic [TLB_N-1:0]         hit_vec,
    input logic                     fill_en
);
    logic [VPN_W-1:0] chk_vpn;
    assign chk_vpn = req_vaddr[VPN_W+OFF_W-1:OFF_W];

    assert_len_fault_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ({1'b0, chk_vpn} >= pt_len))
        |=> (resp_valid && resp_fault == FLT_LEN));

    assert_fault_zero_pa_R11: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault != FLT_NONE) |-> (resp_paddr == '0));

    assert_walk_busy_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(req_ready) |=> (!req_ready ##1 req_ready));

    assert_walk_resp_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(req_ready) |-> ##2 resp_valid);

    assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (flush && !fill_en) |=> (hit_vec == '0));

    assert_fill_clean_R7: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (resp_valid && resp_fault == FLT_NONE));

endmodule

bind paged_xlate pxl_chk #(
    .VPN_W   (VPN_W),
    .OFF_W   (OFF_W),
    .FRAME_W (FRAME_W),
    .TLB_N   (TLB_N)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .pt_len     (pt_len),
    .flush      (flush),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .hit_vec    (hit_vec),
    .fill_en    (fill_en)
);

// File: tb/paged_xlate_tb_top.sv
module paged_xlate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VPN_W   = 4;
    localparam int OFF_W   = 2;
    localparam int FRAME_W = 3;
    localparam int ASID_W  = 4;
    localparam int TLB_N   = 8;
    localparam int PAGES   = 1 << VPN_W;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     req_valid = 1'b0;
    logic                     req_ready;
    logic [VPN_W+OFF_W-1:0]   req_vaddr = '0;
    logic [1:0]               req_kind = '0;
    logic [ASID_W-1:0]        cur_asid = '0;
    logic [VPN_W:0]           pt_len = '0;
    logic                     flush = 1'b0;
    logic                     pt_we = 1'b0;
    logic [VPN_W-1:0]         pt_waddr = '0;
    logic                     pt_wvalid = 1'b0;
    logic [1:0]               pt_wprot = '0;
    logic [FRAME_W-1:0]       pt_wframe = '0;
    logic                     resp_valid;
    logic [FRAME_W+OFF_W-1:0] resp_paddr;
    logic [1:0]               resp_fault;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // reference model state
    int m_pt_v [PAGES];
    int m_pt_p [PAGES];
    int m_pt_f [PAGES];
    int m_tv   [TLB_N];
    int m_tvpn [TLB_N];
    int m_tasid[TLB_N];
    int m_tf   [TLB_N];
    int m_tp   [TLB_N];
    int m_rr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_xlate #(
        .VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .ASID_W(ASID_W), .TLB_N(TLB_N)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .cur_asid(cur_asid),
        .pt_len(pt_len), .flush(flush), .pt_we(pt_we), .pt_waddr(pt_waddr),
        .pt_wvalid(pt_wvalid), .pt_wprot(pt_wprot), .pt_wframe(pt_wframe),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int m_allows(input int prot, input int kind);
        case (prot)
            0: return kind == 0;
            1: return (kind == 0) || (kind == 1);
            2: return kind == 2;
            default: return 0;
        endcase
    endfunction

    task automatic pt_write(input int idx, input int v, input int p, input int f);
        @(negedge clk);
        pt_we = 1'b1; pt_waddr = idx[VPN_W-1:0]; pt_wvalid = v[0];
        pt_wprot = p[1:0]; pt_wframe = f[FRAME_W-1:0];
        @(negedge clk);
        pt_we = 1'b0;
        m_pt_v[idx] = v; m_pt_p[idx] = p; m_pt_f[idx] = f;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < TLB_N; i++) m_tv[i] = 0;
    endtask

    task automatic access(input int vaddr, input int kind, input int asid, input string req);
        int vpn, off, hit_i, lat, e_fault, e_pa, fslot;
        vpn = vaddr >> OFF_W;
        off = vaddr % (1 << OFF_W);
        @(negedge clk);
        chk(resp_valid == 1'b0, req, "idle resp_valid", int'(resp_valid), 0);
        chk(req_ready == 1'b1, req, "idle req_ready", int'(req_ready), 1);
        req_valid = 1'b1;
        req_vaddr = vaddr[VPN_W+OFF_W-1:0];
        req_kind  = kind[1:0];
        cur_asid  = asid[ASID_W-1:0];
        hit_i = -1;
        for (int i = 0; i < TLB_N; i++)
            if (m_tv[i] != 0 && m_tvpn[i] == vpn && m_tasid[i] == asid) hit_i = i;
        if (vpn >= int'(pt_len)) begin
            lat = 1; e_fault = 1; e_pa = 0;
        end else if (hit_i >= 0) begin
            lat = 1;
            if (m_allows(m_tp[hit_i], kind) != 0) begin
                e_fault = 0; e_pa = m_tf[hit_i] * (1 << OFF_W) + off;
            end else begin
                e_fault = 3; e_pa = 0;
            end
        end else begin
            lat = 3;
            if (m_pt_v[vpn] == 0) begin
                e_fault = 2; e_pa = 0;
            end else if (m_allows(m_pt_p[vpn], kind) == 0) begin
                e_fault = 3; e_pa = 0;
            end else begin
                e_fault = 0; e_pa = m_pt_f[vpn] * (1 << OFF_W) + off;
                fslot = -1;
                for (int i = TLB_N - 1; i >= 0; i--) if (m_tv[i] == 0) fslot = i;
                if (fslot < 0) begin
                    fslot = m_rr;
                    m_rr = (m_rr + 1) % TLB_N;
                end
                m_tv[fslot] = 1; m_tvpn[fslot] = vpn; m_tasid[fslot] = asid;
                m_tf[fslot] = m_pt_f[vpn]; m_tp[fslot] = m_pt_p[vpn];
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (lat == 3) begin
            chk(resp_valid == 1'b0, req, "walk cycle1 resp_valid", int'(resp_valid), 0);
            chk(req_ready == 1'b0, req, "walk cycle1 req_ready", int'(req_ready), 0);
            @(negedge clk);
            chk(resp_valid == 1'b0, req, "walk cycle2 resp_valid", int'(resp_valid), 0);
            chk(req_ready == 1'b0, req, "walk cycle2 req_ready", int'(req_ready), 0);
            @(negedge clk);
        end
        chk(resp_valid == 1'b1, req, "resp_valid at expected latency", int'(resp_valid), 1);
        chk(int'(resp_fault) == e_fault, req, "resp_fault", int'(resp_fault), e_fault);
        chk(int'(resp_paddr) == e_pa, req, "resp_paddr", int'(resp_paddr), e_pa);
        chk(req_ready == 1'b1, req, "ready after response", int'(req_ready), 1);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < TLB_N; i++) m_tv[i] = 0;
        for (int i = 0; i < PAGES; i++) m_pt_v[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(resp_valid == 1'b0, "R1", "reset resp_valid", int'(resp_valid), 0);
        chk(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);

        pt_write(0, 1, 1, 5);
        pt_write(1, 1, 0, 6);
        pt_write(2, 1, 2, 1);
        pt_write(3, 1, 1, 2);
        pt_write(4, 0, 1, 7);
        for (int p = 5; p < PAGES; p++) pt_write(p, 1, 1, p % 8);
        pt_len = 5'd16;

        // R1/R2/R4: first access walks; address 0 -> 20
        access(0, 0, 1, "R1_R2_R4");
        // R2/R3: same page hits, 3 -> 23
        access(3, 0, 1, "R2_R3");
        // R2/R4: 4 -> 24, 13 -> 9
        access(4, 0, 1, "R2_R4");
        access(13, 0, 1, "R2_R4");
        access(13, 0, 1, "R3");
        // R5: other identifier misses, original still hits
        access(0, 0, 2, "R5");
        access(1, 0, 1, "R5");
        access(2, 0, 2, "R5");
        // R8: protection on hit and walk paths
        access(5, 1, 1, "R8");
        access(4, 1, 1, "R8");
        access(9, 2, 1, "R8");
        access(8, 2, 1, "R8");
        access(10, 2, 1, "R8");
        access(11, 0, 1, "R8");
        access(2, 1, 1, "R8");
        // R7: invalid page, no fill so repeat walks again
        access(17, 0, 1, "R7_R11");
        access(17, 0, 1, "R7");
        // R6: length bound, buffered page still faults
        pt_len = 5'd3;
        access(12, 0, 1, "R6_R11");
        access(21, 0, 1, "R6");
        access(0, 0, 1, "R6");
        pt_len = 5'd16;
        access(12, 0, 1, "R6");
        // R10: flush empties buffer
        do_flush();
        access(0, 0, 1, "R10");
        access(1, 0, 1, "R10");
        // R9: fill remaining slots, then round-robin eviction
        for (int p = 5; p < 11; p++) access(p * 4, 0, 1, "R9");
        access(12, 0, 1, "R9");
        access(44, 0, 1, "R9");
        access(20, 0, 1, "R9");
        access(0, 0, 1, "R9");
        access(20, 0, 1, "R9");
        access(4, 0, 1, "R9");
        access(2, 0, 1, "R9");
        // R8: walk-path protection fault leaves no entry
        access(8, 1, 1, "R8");
        access(8, 2, 1, "R8");
        access(8, 2, 1, "R8");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule